// File: doc/BRIEF.md
# Split-Mode Internal Data Memory

This block is the on-chip data store of a small 8-bit microcontroller. Every access carries one 8-bit address and an operation code that says how the address is meant. Addresses below 0x80 always reach one shared general RAM. Addresses of 0x80 and above reach one of two separate stores:
- a direct access goes to a special-function-register (SFR) window;
- an indirect access goes to a separate 128-byte extra RAM.

In total 384 bytes sit behind one 8-bit address.

On top of the plain byte accesses the block offers three more kinds of access:
- working-register accesses, which map register number 0 to 7 into one of four banks chosen by two bits of a status SFR;
- single-bit set, clear and test in a bit-addressable byte area;
- stack push and pop through the indirect path, with the stack pointer held in the SFR window.

A side port lets peripheral logic write and read the SFR window directly. The SFR window is a plain register file.

Requests arrive on a valid/ready channel, and each accepted request returns exactly one beat on a valid/ready response channel. The response reports the content of the resolved location as it stands after the operation. `req_ready` is high whenever no response is pending or the pending one is being taken in the same cycle. While a response waits with `rsp_ready` low, no new request is accepted and `rsp_valid` stays high.

Top module: `idata_store`

## Requirements
- R1: After reset these hold: `rsp_valid` is 0, `req_ready` is 1, every storage byte is 0x00 except the stack pointer, the stack pointer (SFR address 0x81) is 0x07, and `bank_sel` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1, and its response is valid from that edge on. `req_ready` equals `!rsp_valid || rsp_ready`. A response held with `rsp_ready` low keeps `rsp_valid` high.
- R3: Operation code 0 is a direct access and code 1 is an indirect access. For addresses 0x00–0x7F both codes reach the same byte, so a byte written through one code is read back through the other.
- R4: For addresses 0x80–0xFF, code 0 reaches the SFR window and code 1 reaches the extra RAM. A write through one code leaves the byte seen through the other code unchanged.
- R5: Operation code 2 is a working-register access. Register n = `req_addr[2:0]` maps to general RAM byte bank*8+n. The bank is bits [4:3] of the status SFR at direct address 0xD0, and `bank_sel` shows it.
- R6: Operation code 3 is a bit access. It targets byte 0x20 + `req_addr[6:3]`, bit `req_addr[2:0]`, and `req_addr[7]` is ignored. A write stores `req_wdata[0]` into that bit only. The response is the bit value in bit 0 with zeros above it.
- R7: Operation code 4 (push) first increments the stack pointer. It then writes `req_wdata` through the indirect path at the new pointer and responds with the pushed byte. Operation code 5 (pop) responds with the indirect byte at the stack pointer and then decrements the pointer. `stack_ptr` shows the pointer.
- R8: A write changes only its addressed location. Every other byte keeps its value.
- R9: For codes 0–3, `req_we` selects a write. The response data is the content of the resolved location after the operation.
- R10: When `ext_sfr_we` is 1, `ext_sfr_wdata` is written into SFR index `ext_sfr_idx` (direct address 0x80 + index). `ext_sfr_rdata` shows that index combinationally. If the core writes the same SFR index in the same cycle, the core value is kept. Writes to different indexes both take effect.
- R11: Operation codes 6 and 7 change no storage, and their response data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Operation code (0 direct, 1 indirect, 2 register, 3 bit, 4 push, 5 pop, 6/7 no-op) |
| req_we | input | 1 | Write select for codes 0–3 |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wdata | input | 8 | Write data (bit 0 for bit writes) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 8 | Content of the resolved location after the operation |
| ext_sfr_we | input | 1 | Side-port SFR write enable |
| ext_sfr_idx | input | 7 | Side-port SFR index |
| ext_sfr_wdata | input | 8 | Side-port SFR write data |
| ext_sfr_rdata | output | 8 | SFR content at `ext_sfr_idx` |
| stack_ptr | output | 8 | Current stack pointer |
| bank_sel | output | 2 | Current working-register bank |

## Verification
A core direct write into the SFR window and a side-port write can land in the same cycle. The bench provokes this by raising `ext_sfr_we` in the very cycle a direct write request is accepted. In one case both target the same index, and the bench expects the core value to survive. In the other case they target neighbouring indexes, and the bench expects both values, reading one through a direct response and the other through `ext_sfr_rdata`. Draining a held response while the next request is accepted is the second overlap the bench forces. It does this by releasing `rsp_ready` while a write request is already waiting.

// File: rtl/idata_pkg.sv
package idata_pkg;

  typedef enum logic [2:0] {
    OP_DIR  = 3'd0,
    OP_IND  = 3'd1,
    OP_REG  = 3'd2,
    OP_BIT  = 3'd3,
    OP_PUSH = 3'd4,
    OP_POP  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_LOW  = 2'd1,
    RG_HIGH = 2'd2,
    RG_SFR  = 2'd3
  } region_e;

endpackage

// File: rtl/idata_resolve.sv
module idata_resolve
  import idata_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32
) (
  input  op_e                         op,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [ADDR_W-1:0]           sp,
  input  logic [BANK_W-1:0]           bank,
  output region_e                     region,
  output logic [ADDR_W-2:0]           idx,
  output logic [DATA_W-1:0]           mask,
  output logic [$clog2(DATA_W)-1:0]   bitsel,
  output logic                        is_bit,
  output logic [ADDR_W-1:0]           sp_next,
  output logic                        sp_upd
);
  localparam int IDX_W  = ADDR_W - 1;
  localparam int BSEL_W = $clog2(DATA_W);

  always_comb begin
    region  = RG_NONE;
    idx     = '0;
    mask    = '1;
    bitsel  = '0;
    is_bit  = 1'b0;
    sp_next = sp;
    sp_upd  = 1'b0;
    unique case (op)
      OP_DIR: begin
        region = addr[ADDR_W-1] ? RG_SFR : RG_LOW;
        idx    = addr[IDX_W-1:0];
      end
      OP_IND: begin
        region = addr[ADDR_W-1] ? RG_HIGH : RG_LOW;
        idx    = addr[IDX_W-1:0];
      end
      OP_REG: begin
        region = RG_LOW;
        idx    = IDX_W'({bank, addr[REG_W-1:0]});
      end
      OP_BIT: begin
        region = RG_LOW;
        idx    = IDX_W'(BIT_BASE) + IDX_W'(addr[IDX_W-1:BSEL_W]);
        bitsel = addr[BSEL_W-1:0];
        mask   = '0;
        mask[addr[BSEL_W-1:0]] = 1'b1;
        is_bit = 1'b1;
      end
      OP_PUSH: begin
        sp_next = sp + 1'b1;
        sp_upd  = 1'b1;
        region  = sp_next[ADDR_W-1] ? RG_HIGH : RG_LOW;
        idx     = sp_next[IDX_W-1:0];
      end
      OP_POP: begin
        sp_next = sp - 1'b1;
        sp_upd  = 1'b1;
        region  = sp[ADDR_W-1] ? RG_HIGH : RG_LOW;
        idx     = sp[IDX_W-1:0];
      end
      default: region = RG_NONE;
    endcase
  end

endmodule

// File: rtl/idata_bytes.sv
module idata_bytes #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        wmask,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end
  end

  assign rdata = mem[raddr];

  // R6 / R8: a masked write touches no bit outside its mask
  p_mask_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((mem[$past(waddr)] ^ $past(mem[waddr])) & ~$past(wmask)) == '0)
    else $error("masked write changed an unmasked bit");

endmodule

// File: rtl/idata_sfr_file.sv
module idata_sfr_file #(
  parameter int DEPTH    = 128,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 3,
  parameter int SP_IDX   = 1,
  parameter int STAT_IDX = 80,
  parameter int SP_RESET = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_we,
  input  logic [$clog2(DEPTH)-1:0] core_idx,
  input  logic [DATA_W-1:0]        core_wdata,
  input  logic                     ext_we,
  input  logic [$clog2(DEPTH)-1:0] ext_idx,
  input  logic [DATA_W-1:0]        ext_wdata,
  output logic [DATA_W-1:0]        ext_rdata,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic [DATA_W-1:0]        sp,
  output logic [BANK_W-1:0]        bank
);
  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        regs[i] <= (i == SP_IDX) ? DATA_W'(SP_RESET) : '0;
    end else begin
      if (ext_we)  regs[ext_idx]  <= ext_wdata;
      if (core_we) regs[core_idx] <= core_wdata;
    end
  end

  assign rd_data   = regs[rd_idx];
  assign ext_rdata = regs[ext_idx];
  assign sp        = regs[SP_IDX];
  assign bank      = regs[STAT_IDX][BANK_LSB +: BANK_W];

  // R10: same-index collision keeps the core value
  p_core_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && ext_we && core_idx == ext_idx) |=> regs[$past(core_idx)] == $past(core_wdata))
    else $error("core write lost a collision");

  // R10: a side-port write lands unless the core takes the same index
  p_ext_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && !(core_we && core_idx == ext_idx)) |=> regs[$past(ext_idx)] == $past(ext_wdata))
    else $error("side-port write did not land");

endmodule

// File: rtl/idata_store.sv
module idata_store
  import idata_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 3,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32,
  parameter int SP_IDX   = 1,
  parameter int STAT_IDX = 80,
  parameter int SP_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ext_sfr_we,
  input  logic [ADDR_W-2:0] ext_sfr_idx,
  input  logic [DATA_W-1:0] ext_sfr_wdata,
  output logic [DATA_W-1:0] ext_sfr_rdata,
  output logic [ADDR_W-1:0] stack_ptr,
  output logic [BANK_W-1:0] bank_sel
);
  localparam int IDX_W  = ADDR_W - 1;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int BSEL_W = $clog2(DATA_W);

  op_e                op;
  region_e            t_region;
  logic [IDX_W-1:0]   t_idx;
  logic [DATA_W-1:0]  t_mask;
  logic [BSEL_W-1:0]  t_bitsel;
  logic               t_isbit;
  logic [ADDR_W-1:0]  sp_next;
  logic               sp_upd;
  logic [DATA_W-1:0]  sp_word;

  logic               accept;
  logic               is_store;
  logic [DATA_W-1:0]  wr_data;
  logic               low_we, high_we, sfr_we;
  logic [IDX_W-1:0]   sfr_widx;
  logic [DATA_W-1:0]  sfr_wdata;

  region_e            r_region;
  logic [IDX_W-1:0]   r_idx;
  logic [BSEL_W-1:0]  r_bitsel;
  logic               r_isbit;
  logic [DATA_W-1:0]  low_rd, high_rd, sfr_rd, sel_byte;

  assign op        = op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign stack_ptr = ADDR_W'(sp_word);

  idata_resolve #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
    .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_resolve (
    .op(op), .addr(req_addr), .sp(stack_ptr), .bank(bank_sel),
    .region(t_region), .idx(t_idx), .mask(t_mask), .bitsel(t_bitsel),
    .is_bit(t_isbit), .sp_next(sp_next), .sp_upd(sp_upd)
  );

  // store decision: explicit writes for codes 0-3, always for push
  always_comb begin
    is_store = 1'b0;
    if (accept) begin
      if (op == OP_PUSH) is_store = 1'b1;
      else if (op inside {OP_DIR, OP_IND, OP_REG, OP_BIT}) is_store = req_we;
    end
  end

  assign wr_data   = t_isbit ? {DATA_W{req_wdata[0]}} : req_wdata;
  assign low_we    = is_store && (t_region == RG_LOW);
  assign high_we   = is_store && (t_region == RG_HIGH);
  assign sfr_we    = (is_store && (t_region == RG_SFR)) || (accept && sp_upd);
  assign sfr_widx  = sp_upd ? IDX_W'(SP_IDX) : t_idx;
  assign sfr_wdata = sp_upd ? DATA_W'(sp_next) : wr_data;

  idata_bytes #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_low (
    .clk(clk), .rst_n(rst_n), .we(low_we), .waddr(t_idx), .wdata(wr_data),
    .wmask(t_mask), .raddr(r_idx), .rdata(low_rd)
  );

  idata_bytes #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_high (
    .clk(clk), .rst_n(rst_n), .we(high_we), .waddr(t_idx), .wdata(wr_data),
    .wmask(t_mask), .raddr(r_idx), .rdata(high_rd)
  );

  idata_sfr_file #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB),
    .SP_IDX(SP_IDX), .STAT_IDX(STAT_IDX), .SP_RESET(SP_RESET)
  ) u_sfr (
    .clk(clk), .rst_n(rst_n),
    .core_we(sfr_we), .core_idx(sfr_widx), .core_wdata(sfr_wdata),
    .ext_we(ext_sfr_we), .ext_idx(ext_sfr_idx), .ext_wdata(ext_sfr_wdata),
    .ext_rdata(ext_sfr_rdata), .rd_idx(r_idx), .rd_data(sfr_rd),
    .sp(sp_word), .bank(bank_sel)
  );

  // registered target; data follows combinationally from it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      r_region  <= RG_NONE;
      r_idx     <= '0;
      r_bitsel  <= '0;
      r_isbit   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      r_region  <= t_region;
      r_idx     <= t_idx;
      r_bitsel  <= t_bitsel;
      r_isbit   <= t_isbit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    unique case (r_region)
      RG_LOW:  sel_byte = low_rd;
      RG_HIGH: sel_byte = high_rd;
      RG_SFR:  sel_byte = sfr_rd;
      default: sel_byte = '0;
    endcase
  end

  assign rsp_data = r_isbit ? DATA_W'(sel_byte[r_bitsel]) : sel_byte;

  // R2: a stalled response is held
  p_hold_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid)
    else $error("held response dropped");

  // R2: nothing is accepted under a stall
  p_stall_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready)
    else $error("request accepted while stalled");

  // R7: push advances the pointer by one
  p_push_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PUSH) |=> stack_ptr == ADDR_W'($past(stack_ptr) + 1'b1))
    else $error("push did not advance stack pointer");

  // R7: pop retreats the pointer by one
  p_pop_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_POP) |=> stack_ptr == ADDR_W'($past(stack_ptr) - 1'b1))
    else $error("pop did not retreat stack pointer");

  // R11: reserved codes respond with zero
  p_nop_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_RSV6 || op == OP_RSV7)) |=> rsp_data == '0)
    else $error("reserved code returned data");

endmodule

// File: tb/test_idata_store.sv
`timescale 1ns/1ps
module test_idata_store;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_ready, rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       ext_sfr_we = 1'b0;
  logic [6:0] ext_sfr_idx = '0;
  logic [7:0] ext_sfr_wdata = '0, ext_sfr_rdata, stack_ptr;
  logic [1:0] bank_sel;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  idata_store i_idata_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ext_sfr_we(ext_sfr_we), .ext_sfr_idx(ext_sfr_idx), .ext_sfr_wdata(ext_sfr_wdata),
    .ext_sfr_rdata(ext_sfr_rdata), .stack_ptr(stack_ptr), .bank_sel(bank_sel)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic we, input logic [7:0] a,
                     input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    req_op = op; req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    rd = rsp_data;
    chk("R2 response valid", {7'b0, rsp_valid}, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 rsp_valid", {7'b0, rsp_valid}, 8'h00);
    chk("R1 req_ready", {7'b0, req_ready}, 8'h01);
    chk("R1 stack_ptr", stack_ptr, 8'h07);
    chk("R1 bank_sel", {6'b0, bank_sel}, 8'h00);
    run(3'd0, 1'b0, 8'h81, 8'h00, v); chk("R1 SP via direct", v, 8'h07);
    run(3'd1, 1'b0, 8'hC0, 8'h00, v); chk("R1 extra RAM zero", v, 8'h00);
  endtask

  task automatic t_alias();
    logic [7:0] v;
    run(3'd0, 1'b1, 8'h30, 8'hA5, v); chk("R9 write response", v, 8'hA5);
    run(3'd1, 1'b0, 8'h30, 8'h00, v); chk("R3 direct->indirect", v, 8'hA5);
    run(3'd1, 1'b1, 8'h7F, 8'h3C, v);
    run(3'd0, 1'b0, 8'h7F, 8'h00, v); chk("R3 indirect->direct", v, 8'h3C);
  endtask

  task automatic t_upper();
    logic [7:0] v;
    run(3'd0, 1'b1, 8'h90, 8'h12, v);
    run(3'd1, 1'b1, 8'h90, 8'h34, v);
    run(3'd0, 1'b0, 8'h90, 8'h00, v); chk("R4 SFR kept", v, 8'h12);
    run(3'd1, 1'b0, 8'h90, 8'h00, v); chk("R4 extra RAM kept", v, 8'h34);
  endtask

  task automatic t_isolation();
    logic [7:0] v;
    run(3'd0, 1'b1, 8'h40, 8'h01, v);
    run(3'd0, 1'b1, 8'h41, 8'h02, v);
    run(3'd0, 1'b1, 8'h41, 8'hFF, v);
    run(3'd0, 1'b0, 8'h40, 8'h00, v); chk("R8 lower neighbour", v, 8'h01);
    run(3'd0, 1'b0, 8'h42, 8'h00, v); chk("R8 upper neighbour", v, 8'h00);
  endtask

  task automatic t_nop();
    logic [7:0] v;
    run(3'd6, 1'b1, 8'h40, 8'h55, v); chk("R11 code 6 response", v, 8'h00);
    run(3'd7, 1'b1, 8'h40, 8'h55, v); chk("R11 code 7 response", v, 8'h00);
    run(3'd0, 1'b0, 8'h40, 8'h00, v); chk("R11 storage untouched", v, 8'h01);
  endtask

  task automatic t_bits();
    logic [7:0] v;
    run(3'd1, 1'b1, 8'h24, 8'h5A, v);
    run(3'd1, 1'b1, 8'h25, 8'hF0, v);
    run(3'd1, 1'b1, 8'h26, 8'h5A, v);
    run(3'd3, 1'b1, 8'h2A, 8'h01, v); chk("R6 set response", v, 8'h01);
    run(3'd3, 1'b1, 8'h2F, 8'hFE, v); chk("R6 clear response", v, 8'h00);
    run(3'd1, 1'b0, 8'h25, 8'h00, v); chk("R6 byte after bit writes", v, 8'h74);
    run(3'd3, 1'b0, 8'hAC, 8'h00, v); chk("R6 addr bit7 ignored", v, 8'h01);
    run(3'd3, 1'b0, 8'h2B, 8'h00, v); chk("R6 test clear bit", v, 8'h00);
    run(3'd0, 1'b0, 8'h24, 8'h00, v); chk("R6 neighbour below", v, 8'h5A);
    run(3'd0, 1'b0, 8'h26, 8'h00, v); chk("R6 neighbour above", v, 8'h5A);
  endtask

  task automatic t_banks();
    logic [7:0] v;
    run(3'd0, 1'b1, 8'hD0, 8'h18, v);
    chk("R5 bank 3 shown", {6'b0, bank_sel}, 8'h03);
    run(3'd2, 1'b1, 8'h05, 8'h77, v); chk("R5 register write response", v, 8'h77);
    run(3'd1, 1'b0, 8'h1D, 8'h00, v); chk("R5 bank 3 R5 at 0x1D", v, 8'h77);
    run(3'd0, 1'b1, 8'hD0, 8'h08, v);
    chk("R5 bank 1 shown", {6'b0, bank_sel}, 8'h01);
    run(3'd2, 1'b1, 8'h05, 8'h66, v);
    run(3'd0, 1'b0, 8'h0D, 8'h00, v); chk("R5 bank 1 R5 at 0x0D", v, 8'h66);
    run(3'd0, 1'b0, 8'h1D, 8'h00, v); chk("R5 other bank kept", v, 8'h77);
    run(3'd2, 1'b0, 8'h05, 8'h00, v); chk("R5 register read", v, 8'h66);
  endtask

  task automatic t_stack();
    logic [7:0] v;
    run(3'd4, 1'b0, 8'h00, 8'hAB, v); chk("R7 push response", v, 8'hAB);
    chk("R7 SP after push", stack_ptr, 8'h08);
    run(3'd1, 1'b0, 8'h08, 8'h00, v); chk("R7 pushed byte at 0x08", v, 8'hAB);
    run(3'd0, 1'b1, 8'h81, 8'h7F, v);
    run(3'd4, 1'b0, 8'h00, 8'hCD, v); chk("R7 push into upper", v, 8'hCD);
    chk("R7 SP 0x80", stack_ptr, 8'h80);
    run(3'd1, 1'b0, 8'h80, 8'h00, v); chk("R7 push used indirect path", v, 8'hCD);
    run(3'd0, 1'b0, 8'h80, 8'h00, v); chk("R7 SFR 0x80 untouched", v, 8'h00);
    run(3'd5, 1'b0, 8'h00, 8'h00, v); chk("R7 pop upper", v, 8'hCD);
    chk("R7 SP after pop", stack_ptr, 8'h7F);
    run(3'd5, 1'b0, 8'h00, 8'h00, v); chk("R7 pop lower", v, 8'h3C);
    chk("R7 SP after second pop", stack_ptr, 8'h7E);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    @(negedge clk);
    req_op = 3'd0; req_we = 1'b1; req_addr = 8'hA0; req_wdata = 8'h11; req_valid = 1'b1;
    ext_sfr_we = 1'b1; ext_sfr_idx = 7'h20; ext_sfr_wdata = 8'h22;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; ext_sfr_we = 1'b0;
    chk("R10 same index core wins", rsp_data, 8'h11);
    @(negedge clk);
    req_op = 3'd0; req_we = 1'b1; req_addr = 8'hA1; req_wdata = 8'h33; req_valid = 1'b1;
    ext_sfr_we = 1'b1; ext_sfr_idx = 7'h22; ext_sfr_wdata = 8'h44;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; ext_sfr_we = 1'b0;
    #1 chk("R10 side port readback", ext_sfr_rdata, 8'h44);
    run(3'd0, 1'b0, 8'hA1, 8'h00, v); chk("R10 core byte landed", v, 8'h33);
    run(3'd0, 1'b0, 8'hA2, 8'h00, v); chk("R10 side byte via direct", v, 8'h44);
    run(3'd1, 1'b0, 8'hA2, 8'h00, v); chk("R10 extra RAM unaffected", v, 8'h00);
  endtask

  task automatic t_backpressure();
    logic [7:0] v;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_op = 3'd1; req_we = 1'b0; req_addr = 8'h30; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_op = 3'd0; req_we = 1'b1; req_addr = 8'h31; req_wdata = 8'h99;
    chk("R2 response held", {7'b0, rsp_valid}, 8'h01);
    chk("R2 ready low under stall", {7'b0, req_ready}, 8'h00);
    chk("R2 held data", rsp_data, 8'hA5);
    @(posedge clk);
    @(negedge clk);
    chk("R2 still held", {7'b0, rsp_valid}, 8'h01);
    chk("R2 held data stable", rsp_data, 8'hA5);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk("R2 next response after drain", rsp_data, 8'h99);
    run(3'd1, 1'b0, 8'h31, 8'h00, v); chk("R2 waiting write applied once", v, 8'h99);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL R2 watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_upper();
    t_isolation();
    t_nop();
    t_bits();
    t_banks();
    t_stack();
    t_collide();
    t_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule